// File: doc/BRIEF.md
# Interrupt-Driven Parallel Printer Port

This block sits on a 16-bit CPU I/O bus and drives a parallel printer. Three ports are decoded: an output byte that is held on the printer data lines, a status byte that reports the printer's busy and acknowledge lines, and a control byte whose bits drive the strobe, auto line feed, initialise and select lines, the data direction, and the interrupt enable. Byte traffic uses the low eight bits of the bus, and the upper bits of every read are zero.

A request flag raises the CPU interrupt line when the printer drops its active-low acknowledge while interrupts are enabled. The acknowledge is sampled through two flip-flops and edge-detected in the system clock domain. The CPU's interrupt acknowledge clears the flag and masks the line at once, so each character produces exactly one request. A driver typically works like this. It writes the control value 0x11 to reset the printer with interrupts on. It then puts a byte on the data port and toggles the strobe between 0x14 and 0x15. When printing is finished, it writes 0x05 to stop further requests.

Top module: `prn_irq_port`

## Requirements
- R1: A write to I/O address 56 latches bus bits 7..0 onto `prn_data` at the next clock edge. A read of address 56 returns that byte. Writes to any other address leave `prn_data` unchanged.
- R2: A write to I/O address 60 stores bus bits 7..0 as the control byte. A read of address 60 returns the stored byte. After reset the control byte is 0x07.
- R3: The printer pins follow the control byte directly. `prn_strobe_n` follows bit 0, `prn_autofd_n` follows bit 1, `prn_init_n` follows bit 2 and `prn_selin_n` follows bit 3. `prn_data_oe` is the inverse of bit 5, so 0 in bit 5 selects output.
- R4: A read of I/O address 58 returns the printer busy level in bit 7 and the acknowledge level in bit 6, each after a two-flip-flop synchroniser. All other bits are 0.
- R5: When control bit 4 is 1 and `prn_ack_n` falls, the request flag sets on the third clock edge after the new level is first present. `irq` then rises unless `iack` is high.
- R6: While `iack` is high, `irq` is 0 in the same cycle. The flag is cleared at the clock edge, and a clear wins over a set at the same edge.
- R7: While control bit 4 is 0, a falling acknowledge does not set the flag. Clearing bit 4 does not drop a request that is already pending.
- R8: Only a high-to-low transition of the acknowledge sets the flag. An acknowledge held low after `iack` does not raise a second request.
- R9: A read of any address other than 56, 58 or 60, or any cycle with `io_rd` low, returns 0 on `io_rdata`. A write to any other address changes neither the control byte nor the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read enable |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational, zero when not addressed |
| iack | input | 1 | CPU interrupt acknowledge, active high |
| irq | output | 1 | Interrupt request to the CPU |
| prn_data | output | 8 | Printer data lines |
| prn_data_oe | output | 1 | Data line output enable |
| prn_strobe_n | output | 1 | Printer strobe, active low |
| prn_autofd_n | output | 1 | Auto line feed, active low |
| prn_init_n | output | 1 | Printer initialise, active low |
| prn_selin_n | output | 1 | Printer select, active low |
| prn_ack_n | input | 1 | Printer acknowledge, active low, asynchronous |
| prn_busy | input | 1 | Printer busy, asynchronous |

## Verification
Register writes show on the pins after one clock edge. The busy and acknowledge levels reach the status read after two edges. A falling acknowledge raises `irq` after three edges, and `iack` masks `irq` in the same cycle, before any edge. The bench drives inputs shortly after each rising edge. A behavioural model updated on the same rising edges predicts every output, and the model and the design are compared on the falling edge, so each result is sampled in the cycle it is due. Separate sequences cover the acknowledge held low, `iack` held across a fall, interrupts disabled before and after a request, and unmapped addresses.

// File: rtl/prn_irq_port.sv
module prn_irq_port #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int DATA_ADDR = 56,
  parameter int STAT_ADDR = 58,
  parameter int CTRL_ADDR = 60,
  parameter logic [7:0] CTRL_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic          iack,
  output logic          irq,
  output logic [7:0]    prn_data,
  output logic          prn_data_oe,
  output logic          prn_strobe_n,
  output logic          prn_autofd_n,
  output logic          prn_init_n,
  output logic          prn_selin_n,
  input  logic          prn_ack_n,
  input  logic          prn_busy
);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_ADDR);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_ADDR);
  localparam int PAD = DW - 8;

  logic [7:0] data_q, ctrl_q;
  logic ack_s1, ack_s2, ack_s3;
  logic busy_s1, busy_s2;
  logic req_q;
  logic ack_fall;

  wire sel_data = io_addr == A_DATA;
  wire sel_stat = io_addr == A_STAT;
  wire sel_ctrl = io_addr == A_CTRL;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= CTRL_RST;
    end else if (io_wr) begin
      if (sel_data) data_q <= io_wdata[7:0];
      if (sel_ctrl) ctrl_q <= io_wdata[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {ack_s1, ack_s2, ack_s3} <= 3'b111;
      {busy_s1, busy_s2} <= 2'b00;
    end else begin
      {ack_s1, ack_s2, ack_s3} <= {prn_ack_n, ack_s1, ack_s2};
      {busy_s1, busy_s2} <= {prn_busy, busy_s1};
    end

  assign ack_fall = ack_s3 & ~ack_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    req_q <= 1'b0;
    else if (iack)                 req_q <= 1'b0;
    else if (ack_fall & ctrl_q[4]) req_q <= 1'b1;

  assign irq = req_q & ~iack;

  assign prn_data     = data_q;
  assign prn_strobe_n = ctrl_q[0];
  assign prn_autofd_n = ctrl_q[1];
  assign prn_init_n   = ctrl_q[2];
  assign prn_selin_n  = ctrl_q[3];
  assign prn_data_oe  = ~ctrl_q[5];

  wire [7:0] stat_byte = {busy_s2, ack_s2, 6'b0};
  wire [7:0] rd_byte = !io_rd   ? 8'h00 :
                       sel_data ? data_q :
                       sel_stat ? stat_byte :
                       sel_ctrl ? ctrl_q : 8'h00;
  assign io_rdata = {{PAD{1'b0}}, rd_byte};

  p_data_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && sel_data) |=> $stable(data_q));

  p_set_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(ctrl_q[4]));

  p_set_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(ack_s3 && !ack_s2));

  p_iack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> !req_q);

  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && sel_ctrl) |=> $stable(ctrl_q));
endmodule

// File: tb/test_prn_irq_port.sv
module test_prn_irq_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0, iack = 0;
  logic [15:0] io_wdata = 0;
  logic [15:0] io_rdata;
  logic irq, prn_data_oe, prn_strobe_n, prn_autofd_n, prn_init_n, prn_selin_n;
  logic [7:0] prn_data;
  logic prn_ack_n = 1, prn_busy = 0;

  int n_chk = 0, n_bad = 0;

  prn_irq_port i_prn_irq_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .iack(iack), .irq(irq),
    .prn_data(prn_data), .prn_data_oe(prn_data_oe), .prn_strobe_n(prn_strobe_n),
    .prn_autofd_n(prn_autofd_n), .prn_init_n(prn_init_n), .prn_selin_n(prn_selin_n),
    .prn_ack_n(prn_ack_n), .prn_busy(prn_busy));

  always #10 clk = ~clk;

  // behavioural model
  int ackq[$] = '{1, 1, 1, 1};
  int busyq[$] = '{0, 0, 0, 0};
  int m_data = 0, m_ctrl = 7;
  bit m_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ackq = '{1, 1, 1, 1};
      busyq = '{0, 0, 0, 0};
      m_data = 0; m_ctrl = 7; m_req = 0;
    end else begin
      ackq.push_front(int'(prn_ack_n)); void'(ackq.pop_back());
      busyq.push_front(int'(prn_busy)); void'(busyq.pop_back());
      if (iack) m_req = 0;
      else if (ackq[3] == 1 && ackq[2] == 0 && m_ctrl[4]) m_req = 1;
      if (io_wr && io_addr == 56) m_data = int'(io_wdata[7:0]);
      if (io_wr && io_addr == 60) m_ctrl = int'(io_wdata[7:0]);
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int exp_rd;
    exp_rd = 0;
    if (io_rd) begin
      if (io_addr == 56) exp_rd = m_data;
      else if (io_addr == 58) exp_rd = busyq[1] * 128 + ackq[1] * 64;
      else if (io_addr == 60) exp_rd = m_ctrl;
    end
    chk("R5 irq", int'(irq), int'(m_req && !iack));
    chk("R1 prn_data", int'(prn_data), m_data);
    chk("R3 strobe", int'(prn_strobe_n), m_ctrl & 1);
    chk("R3 autofd", int'(prn_autofd_n), (m_ctrl >> 1) & 1);
    chk("R3 init", int'(prn_init_n), (m_ctrl >> 2) & 1);
    chk("R3 selin", int'(prn_selin_n), (m_ctrl >> 3) & 1);
    chk("R3 data_oe", int'(prn_data_oe), ((m_ctrl >> 5) & 1) ^ 1);
    chk("R9 rdata", int'(io_rdata), exp_rd);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(int a, int v);
    step(1); io_addr = 8'(a); io_wdata = 16'(v); io_wr = 1;
    step(1); io_wr = 0;
  endtask

  task automatic rd(int a);
    step(1); io_addr = 8'(a); io_rd = 1;
    step(1); io_rd = 0;
  endtask

  initial begin
    #1000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    step(3);
    // R2: reset control value checked on the pins and by reading it back
    rd(60);
    rst_n = 1;
    rd(60);
    // R1: low byte latched, high byte dropped
    wr(56, 16'h12A5); rd(56);
    // R2: control readback; R3 pin mapping
    wr(60, 8'h11); rd(60);
    wr(60, 8'h15); wr(60, 8'h14); wr(60, 8'h15);
    wr(60, 8'h3A); rd(60); wr(60, 8'h15);
    // R4: status synchroniser
    prn_busy = 1; step(1); rd(58); step(2); rd(58);
    prn_busy = 0; step(3);
    // R5: falling acknowledge raises irq
    prn_ack_n = 0; rd(58); step(5);
    // R6: iack masks and clears
    iack = 1; step(1); iack = 0; step(2);
    // R8: held low gives no second request
    step(4); prn_ack_n = 1; step(4);
    // R6: iack held across a fall wins
    iack = 1; prn_ack_n = 0; step(6); iack = 0; step(3);
    prn_ack_n = 1; step(3);
    // R7: disabled, fall ignored
    wr(60, 8'h05); prn_ack_n = 0; step(6); prn_ack_n = 1; step(3);
    // R7: pending request survives disabling
    wr(60, 8'h15); prn_ack_n = 0; step(5);
    wr(60, 8'h05); step(3);
    iack = 1; step(1); iack = 0; prn_ack_n = 1; step(2);
    // R9: unmapped accesses
    wr(57, 16'hFFFF); wr(62, 16'h00FF); wr(61, 16'h0010);
    rd(57); rd(62); rd(0); rd(56); rd(60);
    step(2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule